// File: doc/BRIEF.md
# Warp Register File Cache

This block is a small, fully associative cache that sits between the execution lanes and a large per-warp vector register file. Each entry holds one vector register, which is one 32-bit word per lane. The entry is tagged by the pair (warp id, register number). Instruction results arrive on the write port. A result for a register that the cache already holds updates that entry. Any other result claims a new entry. Source-operand reads that hit return the cached vector. Reads that miss are handed to the main register file on a forward port.

Only warps in the active set may use the cache. Accesses from any other warp bypass it: their writes leave at once on the writeback port, and their reads are forwarded. Deactivating a warp drains all of its entries, one per cycle. Live entries are written back, and entries whose value a last-use read has marked dead are simply dropped. The block holds off all new accesses until the drain is finished. Replacement is first-in first-out, and a victim that is still live is written back.

Top module: `warp_rf_cache`

## Requirements
- R1: A write from an active warp whose tag is absent allocates an entry and produces no writeback. A later read of that tag from an active warp raises `rsp_hit` with the written data in the cycle after the read is accepted.
- R2: A read whose tag is absent, or which comes from an inactive warp, raises `fwd_valid` with the read's warp and register in the cycle after acceptance, and keeps `rsp_hit` low. `rsp_hit` and `fwd_valid` are never high together.
- R3: A write that hits an existing entry updates its data in place and clears its dead mark. It allocates nothing and leaves the entry's position in the replacement order unchanged.
- R4: A write from an inactive warp appears on the writeback port in the next cycle with its own warp, register and data, and the cache is left unchanged.
- R5: A write miss fills a free entry when one exists. When all entries are valid, the write miss replaces the entry that was allocated earliest.
- R6: A replaced entry that is live appears on the writeback port in the cycle after the write, with its warp, register and old data.
- R7: A read that hits with `rd_last` set marks the entry dead. A dead entry leaves the cache without a writeback, whether it is replaced or flushed.
- R8: An accepted deactivate removes the warp from the active set and lowers `ready` from the next cycle. The warp's entries are then drained one per cycle, lowest index first, with a writeback for each live entry. `ready` rises again in the cycle after the last entry is drained.
- R9: A flush leaves the entries of other warps intact.
- R10: When a write that replaces a live entry and a deactivate are accepted in the same cycle, the replaced entry's writeback comes first, in the next cycle. The flush writebacks follow it in later cycles.
- R11: After reset, `ready` is high, `rsp_hit`, `fwd_valid` and `wb_valid` are low, every warp is inactive and every entry is empty.
- R12: While `ready` is low, the write, read, activate and deactivate inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready | output | 1 | High when accesses and warp commands are accepted |
| wr_valid | input | 1 | Result write request |
| wr_warp | input | WARP_W | Warp of the write |
| wr_reg | input | REG_W | Destination register |
| wr_data | input | LANES*32 | Result vector |
| rd_valid | input | 1 | Source read request |
| rd_warp | input | WARP_W | Warp of the read |
| rd_reg | input | REG_W | Source register |
| rd_last | input | 1 | Last-use hint: the value is not needed again |
| rsp_hit | output | 1 | Read served by the cache |
| rsp_data | output | LANES*32 | Read data on a hit |
| fwd_valid | output | 1 | Read handed to the main register file |
| fwd_warp | output | WARP_W | Warp of the forwarded read |
| fwd_reg | output | REG_W | Register of the forwarded read |
| act_valid | input | 1 | Add a warp to the active set |
| act_warp | input | WARP_W | Warp to activate |
| deact_valid | input | 1 | Remove a warp from the active set and flush it |
| deact_warp | input | WARP_W | Warp to deactivate |
| wb_valid | output | 1 | Writeback to the main register file |
| wb_warp | output | WARP_W | Writeback warp |
| wb_reg | output | REG_W | Writeback register |
| wb_data | output | LANES*32 | Writeback vector |

## Verification
Replacement and a warp flush can both need the single writeback port around the same edge. The bench provokes this by filling all entries so that the oldest one belongs to warp 5 and warp 5 owns a second entry. In that state it issues a write miss for warp 4 together with the deactivation of warp 5. The run is judged by the exact order of writeback beats: the evicted oldest entry comes first, in the following cycle, and the flushed entry comes one cycle later. `ready` must stay low until the drain is over, and the warp 4 result written in that cycle must still hit afterwards.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  localparam int unsigned LANE_BITS = 32;

  // which path owns the writeback port in a cycle
  typedef enum logic [1:0] {
    WB_NONE,
    WB_DIRECT,
    WB_EVICT,
    WB_FLUSH
  } wb_src_e;
endpackage

// File: rtl/rfc_tag_match.sv
module rfc_tag_match #(
  parameter int unsigned N      = 8,
  parameter int unsigned WARP_W = 4,
  parameter int unsigned REG_W  = 5,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]      valid,
  input  logic [WARP_W-1:0] ent_warp [N],
  input  logic [REG_W-1:0]  ent_reg  [N],
  input  logic [WARP_W-1:0] wr_warp,
  input  logic [REG_W-1:0]  wr_reg,
  input  logic [WARP_W-1:0] rd_warp,
  input  logic [REG_W-1:0]  rd_reg,
  input  logic [WARP_W-1:0] fl_warp,
  output logic [N-1:0]      wr_vec,
  output logic [N-1:0]      rd_vec,
  output logic [N-1:0]      fl_vec,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [IDX_W-1:0]  fl_idx,
  output logic              wr_any,
  output logic              rd_any,
  output logic              fl_any
);
  // one comparator set per entry
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign wr_vec[g] = valid[g] && ent_warp[g] == wr_warp && ent_reg[g] == wr_reg;
    assign rd_vec[g] = valid[g] && ent_warp[g] == rd_warp && ent_reg[g] == rd_reg;
    assign fl_vec[g] = valid[g] && ent_warp[g] == fl_warp;
  end

  assign wr_any = |wr_vec;
  assign rd_any = |rd_vec;
  assign fl_any = |fl_vec;

  // lowest set index wins
  always_comb begin
    wr_idx = '0;
    rd_idx = '0;
    fl_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (wr_vec[i]) wr_idx = IDX_W'(i);
      if (rd_vec[i]) rd_idx = IDX_W'(i);
      if (fl_vec[i]) fl_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/rfc_age_tracker.sv
module rfc_age_tracker #(
  parameter int unsigned N = 8,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     valid,
  input  logic             alloc,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic             inval,
  input  logic [IDX_W-1:0] inval_idx,
  output logic [IDX_W-1:0] victim_idx,
  output logic [IDX_W-1:0] free_idx,
  output logic             full
);
  // rank = number of valid entries allocated after this one
  logic [IDX_W-1:0] rank_q [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) rank_q[i] <= '0;
    end else if (alloc) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == alloc_idx) rank_q[i] <= '0;
        else if (valid[i])          rank_q[i] <= rank_q[i] + 1'b1;
      end
    end else if (inval) begin
      for (int i = 0; i < N; i++) begin
        if (valid[i] && IDX_W'(i) != inval_idx && rank_q[i] > rank_q[inval_idx])
          rank_q[i] <= rank_q[i] - 1'b1;
      end
    end
  end

  assign full = &valid;

  always_comb begin
    victim_idx = '0;
    free_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (rank_q[i] == IDX_W'(N - 1)) victim_idx = IDX_W'(i);
      if (!valid[i])                  free_idx   = IDX_W'(i);
    end
  end
endmodule

// File: rtl/rfc_data_store.sv
module rfc_data_store #(
  parameter int unsigned N      = 8,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]  raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  // one write port, two asynchronous read ports: distributed RAM
  logic [DATA_W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/rfc_flush_ctrl.sv
module rfc_flush_ctrl #(
  parameter int unsigned WARP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WARP_W-1:0] start_warp,
  input  logic              any_left,
  output logic              busy,
  output logic [WARP_W-1:0] warp
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      warp <= '0;
    end else if (busy) begin
      if (!any_left) busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      warp <= start_warp;
    end
  end
endmodule

// File: rtl/warp_rf_cache.sv
module warp_rf_cache
  import rfc_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned WARP_W      = 4,
  parameter int unsigned REG_W       = 5,
  parameter int unsigned LANES       = 2,
  localparam int unsigned DATA_W     = LANES * LANE_BITS,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES),
  localparam int unsigned NUM_WARPS  = 1 << WARP_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic              ready,
  input  logic              wr_valid,
  input  logic [WARP_W-1:0] wr_warp,
  input  logic [REG_W-1:0]  wr_reg,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  input  logic [WARP_W-1:0] rd_warp,
  input  logic [REG_W-1:0]  rd_reg,
  input  logic              rd_last,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              fwd_valid,
  output logic [WARP_W-1:0] fwd_warp,
  output logic [REG_W-1:0]  fwd_reg,
  input  logic              act_valid,
  input  logic [WARP_W-1:0] act_warp,
  input  logic              deact_valid,
  input  logic [WARP_W-1:0] deact_warp,
  output logic              wb_valid,
  output logic [WARP_W-1:0] wb_warp,
  output logic [REG_W-1:0]  wb_reg,
  output logic [DATA_W-1:0] wb_data
);
  // entry metadata
  logic [NUM_ENTRIES-1:0] valid_q;
  logic [NUM_ENTRIES-1:0] dead_q;
  logic [WARP_W-1:0]      ent_warp_q [NUM_ENTRIES];
  logic [REG_W-1:0]       ent_reg_q  [NUM_ENTRIES];
  logic [NUM_WARPS-1:0]   active_q;

  logic                   flushing;
  logic [WARP_W-1:0]      flush_warp;

  logic [NUM_ENTRIES-1:0] wr_hit_vec, rd_hit_vec, fl_vec;
  logic [IDX_W-1:0]       wr_hit_idx, rd_hit_idx, fl_idx;
  logic                   wr_any, rd_any, fl_any;
  logic [IDX_W-1:0]       victim_idx, free_idx, alloc_idx;
  logic                   full;

  logic accept, wr_go, wr_live, wr_upd, wr_alloc, wr_direct;
  logic evict, evict_wb, rd_go, rd_in_cache, fl_step, fl_wb;
  wb_src_e wb_src;

  logic              st_we;
  logic [IDX_W-1:0]  st_waddr, st_raddr_b;
  logic [DATA_W-1:0] st_rdata_a, st_rdata_b;

  rfc_tag_match #(.N(NUM_ENTRIES), .WARP_W(WARP_W), .REG_W(REG_W)) u_match (
    .valid    (valid_q),
    .ent_warp (ent_warp_q),
    .ent_reg  (ent_reg_q),
    .wr_warp  (wr_warp),
    .wr_reg   (wr_reg),
    .rd_warp  (rd_warp),
    .rd_reg   (rd_reg),
    .fl_warp  (flush_warp),
    .wr_vec   (wr_hit_vec),
    .rd_vec   (rd_hit_vec),
    .fl_vec   (fl_vec),
    .wr_idx   (wr_hit_idx),
    .rd_idx   (rd_hit_idx),
    .fl_idx   (fl_idx),
    .wr_any   (wr_any),
    .rd_any   (rd_any),
    .fl_any   (fl_any)
  );

  rfc_age_tracker #(.N(NUM_ENTRIES)) u_age (
    .clk        (clk),
    .rst        (rst),
    .valid      (valid_q),
    .alloc      (wr_alloc),
    .alloc_idx  (alloc_idx),
    .inval      (fl_step),
    .inval_idx  (fl_idx),
    .victim_idx (victim_idx),
    .free_idx   (free_idx),
    .full       (full)
  );

  rfc_flush_ctrl #(.WARP_W(WARP_W)) u_flush (
    .clk        (clk),
    .rst        (rst),
    .start      (accept && deact_valid),
    .start_warp (deact_warp),
    .any_left   (fl_any),
    .busy       (flushing),
    .warp       (flush_warp)
  );

  // request decode
  always_comb begin
    accept      = !flushing;
    wr_go       = wr_valid && accept;
    wr_live     = wr_go && active_q[wr_warp];
    wr_direct   = wr_go && !active_q[wr_warp];
    wr_upd      = wr_live && wr_any;
    wr_alloc    = wr_live && !wr_any;
    alloc_idx   = full ? victim_idx : free_idx;
    evict       = wr_alloc && full;
    evict_wb    = evict && !dead_q[victim_idx];
    rd_go       = rd_valid && accept;
    rd_in_cache = rd_go && active_q[rd_warp] && rd_any;
    fl_step     = flushing && fl_any;
    fl_wb       = fl_step && !dead_q[fl_idx];

    if (wr_direct)     wb_src = WB_DIRECT;
    else if (evict_wb) wb_src = WB_EVICT;
    else if (fl_wb)    wb_src = WB_FLUSH;
    else               wb_src = WB_NONE;

    st_we      = wr_upd || wr_alloc;
    st_waddr   = wr_upd ? wr_hit_idx : alloc_idx;
    st_raddr_b = (wb_src == WB_FLUSH) ? fl_idx : victim_idx;
  end

  rfc_data_store #(.N(NUM_ENTRIES), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .we      (st_we),
    .waddr   (st_waddr),
    .wdata   (wr_data),
    .raddr_a (rd_hit_idx),
    .rdata_a (st_rdata_a),
    .raddr_b (st_raddr_b),
    .rdata_b (st_rdata_b)
  );

  // metadata and active set
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      dead_q   <= '0;
      active_q <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        ent_warp_q[i] <= '0;
        ent_reg_q[i]  <= '0;
      end
    end else begin
      if (rd_in_cache && rd_last) dead_q[rd_hit_idx] <= 1'b1;
      // a same-cycle write keeps the entry live
      if (wr_upd) dead_q[wr_hit_idx] <= 1'b0;
      if (wr_alloc) begin
        valid_q[alloc_idx]    <= 1'b1;
        dead_q[alloc_idx]     <= 1'b0;
        ent_warp_q[alloc_idx] <= wr_warp;
        ent_reg_q[alloc_idx]  <= wr_reg;
      end
      if (fl_step) begin
        valid_q[fl_idx] <= 1'b0;
        dead_q[fl_idx]  <= 1'b0;
      end
      if (accept) begin
        if (act_valid)   active_q[act_warp]   <= 1'b1;
        if (deact_valid) active_q[deact_warp] <= 1'b0;
      end
    end
  end

  // registered read response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
      fwd_valid <= 1'b0;
      fwd_warp  <= '0;
      fwd_reg   <= '0;
    end else begin
      rsp_hit   <= rd_in_cache;
      rsp_data  <= rd_in_cache ? st_rdata_a : '0;
      fwd_valid <= rd_go && !rd_in_cache;
      fwd_warp  <= rd_warp;
      fwd_reg   <= rd_reg;
    end
  end

  // registered writeback port
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_warp  <= '0;
      wb_reg   <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= (wb_src != WB_NONE);
      unique case (wb_src)
        WB_DIRECT: begin
          wb_warp <= wr_warp;
          wb_reg  <= wr_reg;
          wb_data <= wr_data;
        end
        WB_EVICT: begin
          wb_warp <= ent_warp_q[victim_idx];
          wb_reg  <= ent_reg_q[victim_idx];
          wb_data <= st_rdata_b;
        end
        WB_FLUSH: begin
          wb_warp <= ent_warp_q[fl_idx];
          wb_reg  <= ent_reg_q[fl_idx];
          wb_data <= st_rdata_b;
        end
        default: ;
      endcase
    end
  end

  assign ready = !flushing;
endmodule

// File: rtl/rfc_checker.sv
module rfc_checker #(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned WARP_W      = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     ready,
  input logic                     wr_valid,
  input logic                     rd_valid,
  input logic [WARP_W-1:0]        rd_warp,
  input logic                     deact_valid,
  input logic                     rsp_hit,
  input logic                     fwd_valid,
  input logic                     wb_valid,
  input logic [(1<<WARP_W)-1:0]   active_q,
  input logic [NUM_ENTRIES-1:0]   wr_hit_vec,
  input logic [NUM_ENTRIES-1:0]   rd_hit_vec
);
  // R8
  deact_stalls_chk: assert property (@(posedge clk) disable iff (rst)
    deact_valid && ready |=> !ready);

  // R12
  stall_blocks_access_chk: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !rsp_hit && !fwd_valid);

  // R2
  hit_fwd_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(rsp_hit && fwd_valid));

  // R2
  inactive_read_forwards_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid && ready && !active_q[rd_warp] |=> fwd_valid && !rsp_hit);

  // R1
  unique_tags_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_hit_vec) && $onehot0(rd_hit_vec));

  // R6
  wb_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(wr_valid && ready) || $past(!ready));
endmodule

bind warp_rf_cache rfc_checker #(.NUM_ENTRIES(NUM_ENTRIES), .WARP_W(WARP_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ready       (ready),
  .wr_valid    (wr_valid),
  .rd_valid    (rd_valid),
  .rd_warp     (rd_warp),
  .deact_valid (deact_valid),
  .rsp_hit     (rsp_hit),
  .fwd_valid   (fwd_valid),
  .wb_valid    (wb_valid),
  .active_q    (active_q),
  .wr_hit_vec  (wr_hit_vec),
  .rd_hit_vec  (rd_hit_vec)
);

// File: tb/warp_rf_cache_tb.sv
module warp_rf_cache_tb;
  localparam int LANES = 2;
  localparam int DW    = LANES * 32;

  localparam logic [2:0] OP_IDLE = 3'd0;
  localparam logic [2:0] OP_ACT  = 3'd1;
  localparam logic [2:0] OP_WR   = 3'd2;
  localparam logic [2:0] OP_RD   = 3'd3;
  localparam logic [2:0] OP_RDL  = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  warp;
    logic [4:0]  rg;
    logic [31:0] seed;
    logic        ehit;
    logic        efwd;
    logic        ewb;
  } vec_t;

  function automatic vec_t mk(logic [2:0] op, logic [3:0] w, logic [4:0] r,
                              logic [31:0] s, logic h, logic f, logic b);
    mk = '{op: op, warp: w, rg: r, seed: s, ehit: h, efwd: f, ewb: b};
  endfunction

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    mk(OP_ACT, 4'd1, 5'd0, 32'h0,  1'b0, 1'b0, 1'b0),
    mk(OP_WR,  4'd1, 5'd2, 32'hA1, 1'b0, 1'b0, 1'b0), // R1 allocate
    mk(OP_RD,  4'd1, 5'd2, 32'hA1, 1'b1, 1'b0, 1'b0), // R1 hit
    mk(OP_RD,  4'd1, 5'd3, 32'h0,  1'b0, 1'b1, 1'b0), // R2 miss
    mk(OP_RD,  4'd2, 5'd2, 32'h0,  1'b0, 1'b1, 1'b0), // R2 inactive
    mk(OP_WR,  4'd2, 5'd4, 32'hB2, 1'b0, 1'b0, 1'b1), // R4 direct
    mk(OP_WR,  4'd1, 5'd2, 32'hC3, 1'b0, 1'b0, 1'b0), // R3 update
    mk(OP_RDL, 4'd1, 5'd2, 32'hC3, 1'b1, 1'b0, 1'b0), // R7 mark dead
    mk(OP_WR,  4'd1, 5'd2, 32'hD4, 1'b0, 1'b0, 1'b0), // R3 revive
    mk(OP_RD,  4'd1, 5'd2, 32'hD4, 1'b1, 1'b0, 1'b0), // R3 new data
    mk(OP_ACT, 4'd2, 5'd0, 32'h0,  1'b0, 1'b0, 1'b0),
    mk(OP_WR,  4'd2, 5'd4, 32'hE5, 1'b0, 1'b0, 1'b0), // R1 allocate
    mk(OP_RD,  4'd2, 5'd4, 32'hE5, 1'b1, 1'b0, 1'b0)  // R1 hit
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ready;
  logic wr_valid, rd_valid, rd_last, act_valid, deact_valid;
  logic [3:0] wr_warp, rd_warp, act_warp, deact_warp;
  logic [4:0] wr_reg, rd_reg;
  logic [DW-1:0] wr_data;
  logic rsp_hit, fwd_valid, wb_valid;
  logic [DW-1:0] rsp_data, wb_data;
  logic [3:0] fwd_warp, wb_warp;
  logic [4:0] fwd_reg, wb_reg;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  warp_rf_cache #(.LANES(LANES)) u_dut (
    .clk(clk), .rst(rst), .ready(ready),
    .wr_valid(wr_valid), .wr_warp(wr_warp), .wr_reg(wr_reg), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_warp(rd_warp), .rd_reg(rd_reg), .rd_last(rd_last),
    .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .fwd_valid(fwd_valid), .fwd_warp(fwd_warp), .fwd_reg(fwd_reg),
    .act_valid(act_valid), .act_warp(act_warp),
    .deact_valid(deact_valid), .deact_warp(deact_warp),
    .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg), .wb_data(wb_data)
  );

  function automatic logic [DW-1:0] rep(logic [31:0] s);
    rep = {LANES{s}};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_valid = 0; rd_valid = 0; rd_last = 0; act_valid = 0; deact_valid = 0;
    wr_warp = 0; wr_reg = 0; wr_data = 0; rd_warp = 0; rd_reg = 0;
    act_warp = 0; deact_warp = 0;
  endtask

  // drive happens at posedge+1; outputs of the accepted edge read at posedge+1
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    idle();
    rst = 1;
    repeat (2) tick();
    rst = 0;
  endtask

  task automatic do_act(input logic [3:0] w);
    act_valid = 1; act_warp = w; tick(); idle();
  endtask

  task automatic do_wr(input logic [3:0] w, input logic [4:0] r, input logic [31:0] s);
    wr_valid = 1; wr_warp = w; wr_reg = r; wr_data = rep(s); tick(); idle();
  endtask

  task automatic do_rd(input logic [3:0] w, input logic [4:0] r, input logic last);
    rd_valid = 1; rd_warp = w; rd_reg = r; rd_last = last; tick(); idle();
  endtask

  task automatic expect_wb(input string tag, input logic [3:0] w, input logic [4:0] r,
                           input logic [31:0] s);
    chk(wb_valid == 1'b1, tag, 64'(wb_valid), 64'd1);
    chk(wb_warp == w && wb_reg == r, tag, {55'd0, wb_warp, wb_reg}, {55'd0, w, r});
    chk(wb_data == rep(s), tag, 64'(wb_data), 64'(rep(s)));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  int nwb;
  logic [3:0]  got_w [4];
  logic [4:0]  got_r [4];
  logic [31:0] got_s [4];

  initial begin
    do_reset();
    // R11 reset state
    chk(ready == 1'b1, "R11 ready", 64'(ready), 64'd1);
    chk(!wb_valid && !rsp_hit && !fwd_valid, "R11 outputs idle",
        {61'd0, wb_valid, rsp_hit, fwd_valid}, 64'd0);
    do_wr(4'd0, 5'd0, 32'h77);
    expect_wb("R11 warps inactive after reset (R4)", 4'd0, 5'd0, 32'h77);

    // table walk
    do_reset();
    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VEC[k];
      case (v.op)
        OP_ACT: begin act_valid = 1; act_warp = v.warp; end
        OP_WR:  begin wr_valid = 1; wr_warp = v.warp; wr_reg = v.rg; wr_data = rep(v.seed); end
        OP_RD:  begin rd_valid = 1; rd_warp = v.warp; rd_reg = v.rg; end
        OP_RDL: begin rd_valid = 1; rd_warp = v.warp; rd_reg = v.rg; rd_last = 1; end
        default: ;
      endcase
      tick();
      idle();
      chk(rsp_hit == v.ehit, $sformatf("R1 R2 R3 R7 row %0d hit", k), 64'(rsp_hit), 64'(v.ehit));
      chk(fwd_valid == v.efwd, $sformatf("R2 row %0d fwd", k), 64'(fwd_valid), 64'(v.efwd));
      chk(wb_valid == v.ewb, $sformatf("R4 R6 row %0d wb", k), 64'(wb_valid), 64'(v.ewb));
      if (v.ehit)
        chk(rsp_data == rep(v.seed), $sformatf("R1 R3 row %0d data", k),
            64'(rsp_data), 64'(rep(v.seed)));
      if (v.efwd)
        chk(fwd_warp == v.warp && fwd_reg == v.rg, $sformatf("R2 row %0d fwd tag", k),
            {55'd0, fwd_warp, fwd_reg}, {55'd0, v.warp, v.rg});
      if (v.ewb)
        expect_wb($sformatf("R4 row %0d", k), v.warp, v.rg, v.seed);
    end

    // FIFO replacement and dead drop
    do_reset();
    do_act(4'd3);
    for (int i = 0; i < 8; i++) begin
      do_wr(4'd3, 5'(i), 32'd100 + 32'(i));
      chk(!wb_valid, "R5 free entry used", 64'(wb_valid), 64'd0);
    end
    do_rd(4'd3, 5'd1, 1'b1);
    chk(rsp_hit && rsp_data == rep(32'd101), "R7 last-use read hit", 64'(rsp_data), 64'(rep(32'd101)));
    do_wr(4'd3, 5'd8, 32'd108);
    expect_wb("R5 R6 oldest evicted", 4'd3, 5'd0, 32'd100);
    do_wr(4'd3, 5'd9, 32'd109);
    chk(!wb_valid, "R7 dead victim dropped", 64'(wb_valid), 64'd0);
    do_wr(4'd3, 5'd3, 32'd300);
    chk(!wb_valid, "R3 write hit no allocation", 64'(wb_valid), 64'd0);
    do_wr(4'd3, 5'd10, 32'd110);
    expect_wb("R5 next oldest", 4'd3, 5'd2, 32'd102);
    do_wr(4'd3, 5'd11, 32'd111);
    expect_wb("R3 order kept, data updated", 4'd3, 5'd3, 32'd300);
    do_rd(4'd3, 5'd0, 1'b0);
    chk(fwd_valid && !rsp_hit, "R5 evicted tag misses", 64'(fwd_valid), 64'd1);
    do_rd(4'd3, 5'd8, 1'b0);
    chk(rsp_hit && rsp_data == rep(32'd108), "R5 new tag hits", 64'(rsp_data), 64'(rep(32'd108)));

    // warp flush
    do_reset();
    do_act(4'd1);
    do_act(4'd2);
    do_wr(4'd1, 5'd1, 32'd11);
    do_wr(4'd2, 5'd5, 32'd25);
    do_wr(4'd1, 5'd2, 32'd12);
    do_wr(4'd1, 5'd3, 32'd13);
    do_rd(4'd1, 5'd2, 1'b1);
    deact_valid = 1; deact_warp = 4'd1; tick(); idle();
    chk(!ready, "R8 ready drops", 64'(ready), 64'd0);
    chk(!wb_valid, "R8 no wb at accept", 64'(wb_valid), 64'd0);
    nwb = 0;
    rd_valid = 1; rd_warp = 4'd2; rd_reg = 5'd5; tick(); idle();
    chk(!rsp_hit && !fwd_valid, "R12 read ignored while stalled",
        {62'd0, rsp_hit, fwd_valid}, 64'd0);
    for (int c = 0; c < 20; c++) begin
      if (c > 0) tick();
      if (wb_valid && nwb < 4) begin
        got_w[nwb] = wb_warp; got_r[nwb] = wb_reg; got_s[nwb] = wb_data[31:0]; nwb++;
      end
      if (ready) break;
    end
    chk(ready, "R8 ready returns", 64'(ready), 64'd1);
    chk(nwb == 2, "R7 R8 flush wb count", 64'(nwb), 64'd2);
    chk(got_w[0] == 4'd1 && got_r[0] == 5'd1 && got_s[0] == 32'd11, "R8 first flush wb",
        {23'd0, got_w[0], got_r[0], got_s[0]}, {23'd0, 4'd1, 5'd1, 32'd11});
    chk(got_w[1] == 4'd1 && got_r[1] == 5'd3 && got_s[1] == 32'd13, "R8 second flush wb",
        {23'd0, got_w[1], got_r[1], got_s[1]}, {23'd0, 4'd1, 5'd3, 32'd13});
    do_rd(4'd1, 5'd1, 1'b0);
    chk(fwd_valid && !rsp_hit, "R8 flushed warp inactive", 64'(fwd_valid), 64'd1);
    do_rd(4'd2, 5'd5, 1'b0);
    chk(rsp_hit && rsp_data == rep(32'd25), "R9 other warp kept", 64'(rsp_data), 64'(rep(32'd25)));
    do_act(4'd1);
    do_rd(4'd1, 5'd3, 1'b0);
    chk(fwd_valid && !rsp_hit, "R8 entries removed", 64'(fwd_valid), 64'd1);

    // eviction and flush contending for the writeback port
    do_reset();
    do_act(4'd4);
    do_act(4'd5);
    do_wr(4'd5, 5'd0, 32'd50);
    do_wr(4'd5, 5'd1, 32'd51);
    for (int i = 0; i < 6; i++) do_wr(4'd4, 5'(i), 32'd400 + 32'(i));
    wr_valid = 1; wr_warp = 4'd4; wr_reg = 5'd6; wr_data = rep(32'd406);
    deact_valid = 1; deact_warp = 4'd5;
    tick(); idle();
    expect_wb("R10 eviction first", 4'd5, 5'd0, 32'd50);
    chk(!ready, "R10 flush pending", 64'(ready), 64'd0);
    nwb = 0;
    for (int c = 0; c < 20; c++) begin
      tick();
      if (wb_valid && nwb < 4) begin
        got_w[nwb] = wb_warp; got_r[nwb] = wb_reg; got_s[nwb] = wb_data[31:0]; nwb++;
      end
      if (ready) break;
    end
    chk(nwb == 1, "R10 flush wb count", 64'(nwb), 64'd1);
    chk(got_w[0] == 4'd5 && got_r[0] == 5'd1 && got_s[0] == 32'd51, "R10 flush wb after eviction",
        {23'd0, got_w[0], got_r[0], got_s[0]}, {23'd0, 4'd5, 5'd1, 32'd51});
    do_rd(4'd4, 5'd6, 1'b0);
    chk(rsp_hit && rsp_data == rep(32'd406), "R10 new entry kept", 64'(rsp_data), 64'(rep(32'd406)));

    finish_run();
  end
endmodule